// File: doc/BRIEF.md
# Two-Speed Oscillator Start-Up Sequencer

This block chooses the system clock of a core while an external crystal oscillator settles. On a start event (power-on once the power-up delay has run out, or a wake from sleep) it counts 1024 cycles of the external oscillator. For that interval the core can already run from the internal oscillator. Once the count is complete, the block moves the core to the external clock. The handover cannot produce a clipped pulse: the internal clock is released on one of its own falling edges, the system clock then stays low, and the external clock is taken on one of its own falling edges.

The count and the two-speed behaviour apply only to the three crystal modes. External-clock and RC modes switch at once with no count. If the two-speed feature is off in a crystal mode, the system clock stays low until the count is complete. If software has chosen the internal oscillator, the core stays on it. A sleep request returns the block to idle from any state. If the request arrives during a count, the count is lost and the done status stays clear.

The FSM states are IDLE, WARM (counting on the internal clock), GATED (counting with the clock stopped), EXT (running on the external clock) and INTONLY (running on the internal clock by software choice). The transitions are:
- IDLE to INTONLY, EXT, WARM or GATED on a start event, once both clock-domain crossings read clear.
- WARM or GATED to EXT on the synchronised terminal count.
- Any state back to IDLE on a sleep request.

Top module: `twospeed_startup_seq`

## Requirements
- R1: After reset and before any start event, clk_sys stays low and startup_done and on_internal are 0.
- R2: In a crystal mode (osc_mode codes 0, 1, 2) with twospeed_en=1 and sw_sel_int=0, clk_sys follows clk_int after a start event, on_internal is 1 and startup_done is 0 while the count runs.
- R3: In a crystal mode, startup_done rises no earlier than 1024 clk_ext periods after the start event and within 200 ns after that point, and it rises on a falling edge of clk_int.
- R4: Once startup_done is 1, clk_sys stays low until at least one falling edge of clk_ext has passed. Its next rising edge is a rising edge of clk_ext, it then follows clk_ext, and on_internal is 0.
- R5: In a crystal mode with twospeed_en=0 and sw_sel_int=0, clk_sys stays low during the count and follows clk_ext after the count.
- R6: In osc_mode codes 3 to 7 with sw_sel_int=0 there is no count. startup_done is 1 within two clk_int periods of the start event, and clk_sys follows clk_ext.
- R7: With sw_sel_int=1 at the start event, clk_sys follows clk_int for as long as the block runs, on_internal stays 1 and startup_done stays 0, whatever osc_mode is.
- R8: A sleep request in any running state brings the block to idle: clk_sys goes low and startup_done and on_internal go to 0. A start event after a sleep request that cut a count short runs a full new count of 1024 clk_ext cycles.
- R9: Every high and low phase of clk_sys lasts at least as long as the shorter half-period of the two source clocks, so switching never produces a glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock |
| clk_ext | input | 1 | External oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_mode | input | 3 | Clock mode: 0-2 crystal (low, medium, high gain), 3 external clock, 4-7 RC or other non-crystal |
| twospeed_en | input | 1 | Enables running on the internal clock during the count |
| sw_sel_int | input | 1 | Software choice of the internal clock; must be 0 for the automatic switch |
| start_pulse | input | 1 | Start event, sampled on clk_int falling edges |
| sleep_req | input | 1 | Sleep request, sampled on clk_int falling edges |
| clk_sys | output | 1 | Selected system clock |
| startup_done | output | 1 | Set when the core runs from the external clock |
| on_internal | output | 1 | Set while the core runs from the internal clock |

## Verification
Start and sleep are sampled on the next falling edge of clk_int, so on_internal, startup_done and the clk_int gate change half a clk_int period after the input is driven. The external gate then follows on the next falling edge of clk_ext. The terminal count arrives 1024 clk_ext cycles plus about two cycles of synchroniser latency on each side after the start event. The bench therefore checks the clock source by counting clk_sys edges in 400 ns windows that begin 80 ns after a stimulus, or more than 7 µs after it, well away from every switching point. The done time is checked against a window from 1024 external periods to 200 ns beyond that. The phase-width monitor and the edge-order flags check the instant of each switch.

// File: rtl/tss_pkg.sv
package tss_pkg;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_XTAL_MAX = 3'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WARM,
        ST_GATED,
        ST_EXT,
        ST_INTONLY
    } seq_state_t;

    function automatic logic is_xtal(input logic [MODE_W-1:0] mode);
        return mode <= MODE_XTAL_MAX;
    endfunction

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tss_ost_counter.sv
module tss_ost_counter #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk_ext,
    input  logic rst_n,
    input  logic run,
    output logic term
);
    localparam int CNT_W = $clog2(OST_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_ext or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            term  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            term  <= 1'b0;
        end else if (!term) begin
            if (cnt_q == LAST) term  <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tss_fsm.sv
module tss_fsm
    import tss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] osc_mode,
    input  logic              twospeed_en,
    input  logic              sw_sel_int,
    input  logic              term_int,
    input  logic              ext_busy,
    output logic              sel_int,
    output logic              on_internal,
    output logic              startup_done,
    output logic              want_ext,
    output logic              want_count
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_pulse && !sleep_req && !term_int && !ext_busy) begin
                    if (sw_sel_int)             state_d = ST_INTONLY;
                    else if (!is_xtal(osc_mode)) state_d = ST_EXT;
                    else if (twospeed_en)        state_d = ST_WARM;
                    else                         state_d = ST_GATED;
                end
            end
            ST_WARM, ST_GATED: begin
                if (sleep_req)     state_d = ST_IDLE;
                else if (term_int) state_d = ST_EXT;
            end
            ST_EXT, ST_INTONLY: begin
                if (sleep_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_int      <= 1'b0;
            on_internal  <= 1'b0;
            startup_done <= 1'b0;
            want_ext     <= 1'b0;
            want_count   <= 1'b0;
        end else begin
            sel_int      <= (state_d == ST_WARM) || (state_d == ST_INTONLY);
            on_internal  <= (state_d == ST_WARM) || (state_d == ST_INTONLY);
            startup_done <= (state_d == ST_EXT);
            want_ext     <= (state_d == ST_EXT);
            want_count   <= (state_d == ST_WARM) || (state_d == ST_GATED);
        end
    end
endmodule

// File: rtl/twospeed_startup_seq.sv
module twospeed_startup_seq
    import tss_pkg::*;
#(
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_int,
    input  logic              clk_ext,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] osc_mode,
    input  logic              twospeed_en,
    input  logic              sw_sel_int,
    input  logic              start_pulse,
    input  logic              sleep_req,
    output logic              clk_sys,
    output logic              startup_done,
    output logic              on_internal
);
    logic clk_int_n;
    logic sel_int, want_ext, want_count;
    logic run_ext, term_ext, term_int;
    logic ext_on, ext_busy;

    assign clk_int_n = ~clk_int;

    tss_fsm u_fsm (
        .clk          (clk_int_n),
        .rst_n        (rst_n),
        .start_pulse  (start_pulse),
        .sleep_req    (sleep_req),
        .osc_mode     (osc_mode),
        .twospeed_en  (twospeed_en),
        .sw_sel_int   (sw_sel_int),
        .term_int     (term_int),
        .ext_busy     (ext_busy),
        .sel_int      (sel_int),
        .on_internal  (on_internal),
        .startup_done (startup_done),
        .want_ext     (want_ext),
        .want_count   (want_count)
    );

    // count request crosses into the external domain
    tss_sync #(.STAGES(SYNC_STAGES)) u_sync_run (
        .clk (clk_ext), .rst_n (rst_n), .d (want_count), .q (run_ext)
    );

    tss_ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk_ext (clk_ext), .rst_n (rst_n), .run (run_ext), .term (term_ext)
    );

    // terminal count and external-gate state cross back, on clk_int falling edges
    tss_sync #(.STAGES(SYNC_STAGES)) u_sync_term (
        .clk (clk_int_n), .rst_n (rst_n), .d (term_ext), .q (term_int)
    );

    tss_sync #(.STAGES(SYNC_STAGES)) u_sync_busy (
        .clk (clk_int_n), .rst_n (rst_n), .d (ext_on), .q (ext_busy)
    );

    // external gate changes only while clk_ext is low
    always_ff @(negedge clk_ext or negedge rst_n) begin
        if (!rst_n) ext_on <= 1'b0;
        else        ext_on <= want_ext;
    end

    assign clk_sys = (clk_int & sel_int) | (clk_ext & ext_on);
endmodule

// File: rtl/tss_checker.sv
module tss_checker
    import tss_pkg::*;
(
    input logic              clk_int,
    input logic              clk_ext,
    input logic              rst_n,
    input logic [MODE_W-1:0] osc_mode,
    input logic              sleep_req,
    input logic              startup_done,
    input logic              on_internal,
    input logic              sel_int,
    input logic              ext_on,
    input logic              run_ext,
    input logic              term_ext,
    input logic              term_int
);
    assert_sel_exclusive_R9: assert property (
        @(posedge clk_int) disable iff (!rst_n) !(sel_int && ext_on));

    assert_done_not_internal_R2: assert property (
        @(negedge clk_int) disable iff (!rst_n) on_internal |-> !startup_done);

    assert_done_needs_count_R3: assert property (
        @(negedge clk_int) disable iff (!rst_n)
        $rose(startup_done) |-> (term_int || !is_xtal(osc_mode)));

    assert_sleep_idles_R8: assert property (
        @(negedge clk_int) disable iff (!rst_n)
        sleep_req |=> (!startup_done && !on_internal));

    assert_count_clears_R8: assert property (
        @(posedge clk_ext) disable iff (!rst_n) !run_ext |=> !term_ext);
endmodule

bind twospeed_startup_seq tss_checker u_chk (
    .clk_int      (clk_int),
    .clk_ext      (clk_ext),
    .rst_n        (rst_n),
    .osc_mode     (osc_mode),
    .sleep_req    (sleep_req),
    .startup_done (startup_done),
    .on_internal  (on_internal),
    .sel_int      (sel_int),
    .ext_on       (ext_on),
    .run_ext      (run_ext),
    .term_ext     (term_ext),
    .term_int     (term_int)
);

// File: tb/twospeed_startup_seq_tb.sv
`timescale 1ns/100ps
module twospeed_startup_seq_tb;
    localparam int      CLK_PERIOD   = 20;
    localparam realtime EXT_PERIOD   = 6.0;
    localparam int      OST          = 1024;
    localparam int      WATCHDOG_CYC = 20000;
    localparam realtime MIN_PHASE    = 2.9;
    localparam int CLS_OFF = 0, CLS_INT = 1, CLS_EXT = 2;

    // {mode[2:0], en, sw, warm_cls[1:0], final_cls[1:0], done}
    localparam logic [9:0] VEC [6] = '{
        {3'd0, 1'b1, 1'b0, 2'd1, 2'd2, 1'b1},
        {3'd2, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1},
        {3'd3, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1},
        {3'd5, 1'b0, 1'b0, 2'd2, 2'd2, 1'b1},
        {3'd1, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0},
        {3'd7, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0}
    };

    logic clk_int = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
    logic [2:0] osc_mode = 3'd0;
    logic twospeed_en = 1'b0, sw_sel_int = 1'b0, start_pulse = 1'b0, sleep_req = 1'b0;
    logic clk_sys, startup_done, on_internal;

    int n_checks = 0, n_fail = 0, sys_edges = 0, glitches = 0;
    bit finished = 0, have_last = 0;
    realtime last_edge, t_s, t_done;
    bit done_clk_int, ext_fell, seen_first, first_ext, first_after_fall;

    twospeed_startup_seq u_dut (
        .clk_int (clk_int), .clk_ext (clk_ext), .rst_n (rst_n),
        .osc_mode (osc_mode), .twospeed_en (twospeed_en), .sw_sel_int (sw_sel_int),
        .start_pulse (start_pulse), .sleep_req (sleep_req),
        .clk_sys (clk_sys), .startup_done (startup_done), .on_internal (on_internal)
    );

    always #(CLK_PERIOD/2) clk_int = ~clk_int;
    initial begin
        #0.5;
        forever #(EXT_PERIOD/2.0) clk_ext = ~clk_ext;
    end

    always @(posedge clk_sys) sys_edges++;
    always @(clk_sys) begin
        if (rst_n && have_last && ($realtime - last_edge) < MIN_PHASE) glitches++;
        last_edge = $realtime;
        have_last = 1;
    end
    always @(posedge startup_done) begin
        t_done = $realtime;
        done_clk_int = clk_int;
    end
    always @(negedge clk_ext) if (startup_done) ext_fell = 1;
    always @(posedge clk_sys) if (startup_done && !seen_first) begin
        seen_first = 1;
        first_ext = clk_ext;
        first_after_fall = ext_fell;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        seen_first = 0; ext_fell = 0; t_done = 0; done_clk_int = 1;
    endtask

    task automatic pulse_start();
        @(posedge clk_int);
        clear_flags();
        start_pulse = 1'b1;
        t_s = $realtime;
        @(posedge clk_int);
        start_pulse = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(posedge clk_int);
        sleep_req = 1'b1;
        @(posedge clk_int);
        sleep_req = 1'b0;
    endtask

    task automatic measure(output int cls);
        int e0, n;
        e0 = sys_edges;
        #400;
        n = sys_edges - e0;
        if (n == 0)                 cls = CLS_OFF;
        else if (n >= 15 && n <= 25) cls = CLS_INT;
        else if (n >= 55 && n <= 75) cls = CLS_EXT;
        else                         cls = 3;
    endtask

    function automatic string tag_of(input logic [2:0] m, input logic en, input logic sw);
        if (sw) return "R7";
        if (m > 3'd2) return "R6";
        return en ? "R2" : "R5";
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(WATCHDOG_CYC * CLK_PERIOD);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int cls;
        #45 rst_n = 1'b1;
        #60;
        // R1: nothing runs before a start event
        measure(cls);
        check(cls == CLS_OFF, "R1", cls, CLS_OFF);
        check(startup_done == 1'b0, "R1", startup_done, 0);
        check(on_internal == 1'b0, "R1", on_internal, 0);

        for (int i = 0; i < 6; i++) begin
            logic [9:0] v;
            string tag;
            bit xtal_auto, direct;
            v = VEC[i];
            osc_mode = v[9:7]; twospeed_en = v[6]; sw_sel_int = v[5];
            tag = tag_of(v[9:7], v[6], v[5]);
            xtal_auto = (v[9:7] <= 3'd2) && !v[5];
            direct = (v[9:7] > 3'd2) && !v[5];
            pulse_start();
            #80;
            measure(cls);
            check(cls == int'(v[4:3]), tag, cls, int'(v[4:3]));
            check(on_internal == (v[4:3] == 2'd1), tag, on_internal, int'(v[4:3] == 2'd1));
            check(startup_done == direct, tag, startup_done, int'(direct));
            #7000;
            measure(cls);
            check(cls == int'(v[2:1]), tag, cls, int'(v[2:1]));
            check(startup_done == v[0], tag, startup_done, int'(v[0]));
            if (v[2:1] == 2'd2) begin
                // R4: hold low until an external falling edge, then take clk_ext
                check(seen_first && first_ext && first_after_fall, "R4",
                      int'(seen_first && first_ext && first_after_fall), 1);
                check(on_internal == 1'b0, "R4", on_internal, 0);
            end
            if (xtal_auto) begin
                // R3: done after the full count, on a clk_int falling edge
                check((t_done - t_s) >= OST * EXT_PERIOD, "R3", int'(t_done - t_s), int'(OST * EXT_PERIOD));
                check((t_done - t_s) <= OST * EXT_PERIOD + 200.0, "R3", int'(t_done - t_s),
                      int'(OST * EXT_PERIOD + 200.0));
                check(done_clk_int == 1'b0, "R3", done_clk_int, 0);
            end
            if (direct)
                check((t_done - t_s) <= 2.0 * CLK_PERIOD, "R6", int'(t_done - t_s), 2 * CLK_PERIOD);
            pulse_sleep();
            #300;
        end

        // R8: sleep during the count aborts it
        osc_mode = 3'd1; twospeed_en = 1'b1; sw_sel_int = 1'b0;
        pulse_start();
        #2000;
        pulse_sleep();
        #300;
        measure(cls);
        check(cls == CLS_OFF, "R8", cls, CLS_OFF);
        check(startup_done == 1'b0, "R8", startup_done, 0);
        check(on_internal == 1'b0, "R8", on_internal, 0);
        #6000;
        check(startup_done == 1'b0, "R8", startup_done, 0);
        // R8: a restart after the abort runs a full new count
        pulse_start();
        #3000;
        check(startup_done == 1'b0, "R8", startup_done, 0);
        check(on_internal == 1'b1, "R8", on_internal, 1);
        #4500;
        check(startup_done == 1'b1, "R8", startup_done, 1);
        check((t_done - t_s) >= OST * EXT_PERIOD, "R8", int'(t_done - t_s), int'(OST * EXT_PERIOD));
        // R8: sleep while on the external clock stops it
        pulse_sleep();
        #300;
        measure(cls);
        check(cls == CLS_OFF, "R8", cls, CLS_OFF);
        check(startup_done == 1'b0, "R8", startup_done, 0);

        // R9: no clipped phase on clk_sys at any switch
        check(glitches == 0, "R9", glitches, 0);
        finish_run();
    end
endmodule